// File: doc/BRIEF.md
# Cache Flush and Snoop Coherence Sequencer

This block coordinates maintenance work between a split instruction cache and data cache. It turns four kinds of trigger into writebacks and invalidations. The first is a flush raised on an external pin. The second is a flush raised by a write-back-and-invalidate instruction. The third is a cross-cache snoop: an instruction-cache line fill probes the data cache, and a data-cache write probes the instruction cache. The fourth is an external inquire cycle. Each trigger follows the same rule: modified data is written back before anything is invalidated.

A flush walks every data-cache line. Sets are visited in ascending order and ways from 0 to 3 within a set. A writeback request is issued for each modified line and clean lines are skipped. After the last line, both caches are invalidated with one bulk strobe each, and the trigger's own acknowledge is pulsed. The cache arrays sit outside the block and answer two same-cycle lookup ports: a walk port indexed by set and way, and an address probe port. Writeback requests are one-cycle pulses whose bus timing is handled downstream.

Snoops and inquires are first captured in one holding slot per source. They are served one at a time while no flush walk is running. This means an event that arrives during a walk waits until the walk has been acknowledged.

Top module: `cache_maint_seq`

## Requirements
- R1: After reset every writeback, invalidate and acknowledge output is low and the sequencer is idle.
- R2: A flush accepted at a clock edge starts a walk in the next cycle. The walk spends one cycle on each line, in ascending set order and ways 0 to 3 within a set. In a line's cycle, wb_req_o pulses only if that line is valid and modified, with wb_addr_o = {tag, set, 5'b00000}.
- R3: In the cycle after the last line's visit, dc_inv_all_o and ic_inv_all_o pulse together for exactly one cycle, after every writeback of that flush.
- R4: In the cycle after the bulk invalidate, flush_done_pin_o pulses for one cycle if the pin flush started the walk, and flush_done_instr_o pulses if the instruction flush did. Both pulse if both were requested in the same accepting cycle.
- R5: A flush request that arrives while the sequencer is not idle is ignored: it causes no further walk and no acknowledge.
- R6: An instruction-fill snoop probes the data cache at its address. A modified hit gives a writeback of the aligned line, then dc_inv_line_o in the next cycle. A clean hit gives dc_inv_line_o only. A miss gives nothing.
- R7: A data-write snoop probes the instruction cache. A hit pulses ic_inv_line_o with inv_addr_o set to the aligned line address. A miss gives nothing.
- R8: An inquire that hits a modified data line gives one writeback of that line and no invalidation. A clean hit or a miss gives nothing.
- R9: An event arriving during a walk is held and served after the acknowledge. Pending events are served one at a time in the order inquire, then instruction-fill snoop, then data-write snoop. Each event's probe begins two cycles after its arrival edge, at the earliest.
- R10: Every writeback carries wb_be_o = 8'hFF and an address whose low five bits are zero. wb_be_o is zero when no writeback is requested.
- R11: When the sequencer is idle and a flush request coincides with pending snoop or inquire events, the flush walk runs first and the events follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_pin_i | input | 1 | Flush request from the external pin |
| flush_instr_i | input | 1 | Flush request from the write-back-and-invalidate instruction |
| icfill_valid_i | input | 1 | Instruction-cache line fill (snoop the data cache) |
| icfill_addr_i | input | ADDR_W | Address of the instruction fill |
| dcwr_valid_i | input | 1 | Data-cache line write (snoop the instruction cache) |
| dcwr_addr_i | input | ADDR_W | Address of the data write |
| inq_valid_i | input | 1 | External inquire cycle |
| inq_addr_i | input | ADDR_W | Inquire address |
| walk_set_o | output | IDX_W | Set under visit during a walk |
| walk_way_o | output | WAY_W | Way under visit during a walk |
| walk_dirty_i | input | 1 | Visited line is valid and modified |
| walk_tag_i | input | TAG_W | Tag of the visited line |
| probe_addr_o | output | ADDR_W | Address presented to both probe lookups |
| probe_dc_hit_i | input | 1 | Probe address hits the data cache |
| probe_dc_dirty_i | input | 1 | The data-cache hit line is modified |
| probe_ic_hit_i | input | 1 | Probe address hits the instruction cache |
| wb_req_o | output | 1 | One-cycle writeback request |
| wb_addr_o | output | ADDR_W | Line-aligned writeback start address |
| wb_be_o | output | 8 | Byte enables of the writeback |
| dc_inv_all_o | output | 1 | Invalidate the whole data cache |
| ic_inv_all_o | output | 1 | Invalidate the whole instruction cache |
| dc_inv_line_o | output | 1 | Invalidate one data-cache line |
| ic_inv_line_o | output | 1 | Invalidate one instruction-cache line |
| inv_addr_o | output | ADDR_W | Line address for the single-line invalidates |
| flush_done_pin_o | output | 1 | Completion pulse of a pin flush |
| flush_done_instr_o | output | 1 | Completion pulse of an instruction flush |

## Verification
The assertions take the lookup ports to answer in the same cycle and consistently with the address or set and way driven out. They also assume that a source never raises a new event while its holding slot is still occupied, so an event is never overwritten before it is served. The bench drives lookups from its own cache image and combinationally from the block's lookup outputs. After an event it waits long enough for that source's slot to drain before raising the same source again, and during a walk it issues at most one event per source. The cache image changes only while no walk, probe or pending event is in progress.

// File: rtl/cms_pkg.sv
// Package: shared constants and types of the cache maintenance sequencer.
// Assumes: a 32-byte cache line and an 8-byte data bus.
package cms_pkg;
    localparam int OFF_W = 5;   // byte offset bits within a line
    localparam int BE_W  = 8;   // byte enables of one bus beat
    localparam int NSRC  = 3;   // number of event sources held in slots

    // Sequencer states
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_WALK   = 3'd1,
        S_INVALL = 3'd2,
        S_DONE   = 3'd3,
        S_PROBE  = 3'd4,
        S_INVAL  = 3'd5
    } cms_state_e;

    // Event kinds; the value is also the slot index and the service priority (0 first)
    typedef enum logic [1:0] {
        K_INQ = 2'd0,
        K_ICF = 2'd1,
        K_DCW = 2'd2
    } cms_kind_e;
endpackage

// File: rtl/cms_event_slot.sv
// Module: one holding slot for a snoop or inquire event.
// Captures the address when the event arrives and holds it until the controller takes it.
// Assumes: a source never raises a new event while its slot is full.
module cms_event_slot #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid_i,
    input  logic [ADDR_W-1:0] ev_addr_i,
    input  logic              take_i,
    output logic              full_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic              full_q;
    logic [ADDR_W-1:0] addr_q;

    // Purpose: set on arrival, clear when the controller takes the event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            addr_q <= '0;
        end else if (ev_valid_i) begin
            full_q <= 1'b1;
            addr_q <= ev_addr_i;
        end else if (take_i) begin
            full_q <= 1'b0;
        end
    end

    assign full_o = full_q;
    assign addr_o = addr_q;

    // R9: an event must never overwrite one that is still held
    p_slot_no_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid_i |-> !full_q);

    // R9: a taken event leaves the slot empty in the next cycle
    p_slot_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !ev_valid_i) |=> !full_q);
endmodule

// File: rtl/cms_walk_ctr.sv
// Module: set/way position counter of the flush walk.
// Sets go in ascending order, ways from 0 to WAYS-1 within a set.
// Assumes: start_i and step_i are never high in the same cycle.
module cms_walk_ctr #(
    parameter int SETS = 16,
    parameter int WAYS = 4,
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             step_i,
    output logic [IDX_W-1:0] set_o,
    output logic [WAY_W-1:0] way_o,
    output logic             last_o
);
    localparam logic [IDX_W-1:0] SET_LAST = IDX_W'(SETS - 1);
    localparam logic [WAY_W-1:0] WAY_LAST = WAY_W'(WAYS - 1);

    logic [IDX_W-1:0] set_q;
    logic [WAY_W-1:0] way_q;

    // Purpose: clear on start, advance the way, then the set, on each step
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            set_q <= '0;
            way_q <= '0;
        end else if (step_i) begin
            if (way_q == WAY_LAST) begin
                way_q <= '0;
                set_q <= (set_q == SET_LAST) ? '0 : set_q + 1'b1;
            end else begin
                way_q <= way_q + 1'b1;
            end
        end
    end

    assign set_o  = set_q;
    assign way_o  = way_q;
    assign last_o = (set_q == SET_LAST) && (way_q == WAY_LAST);

    // R2: within a set the ways are visited in ascending order
    p_walk_way_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !start_i && way_q != WAY_LAST) |=> (way_q == $past(way_q) + 1'b1) && (set_q == $past(set_q)));

    // R2: after the last way the walk moves to the next set, way 0
    p_walk_set_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !start_i && way_q == WAY_LAST && set_q != SET_LAST) |=> (way_q == '0) && (set_q == $past(set_q) + 1'b1));
endmodule

// File: rtl/cms_ctrl.sv
// Module: sequencer state machine.
// It accepts flushes only when idle, runs the line walk, the bulk invalidate and the acknowledge.
// It serves held events one at a time through the probe port.
// Assumes: lookup responses are valid in the same cycle as the address or position that is driven.
module cms_ctrl
    import cms_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 23
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush_pin_i,
    input  logic                         flush_instr_i,
    input  logic [NSRC-1:0]              slot_full_i,
    input  logic [NSRC-1:0][ADDR_W-1:0]  slot_addr_i,
    output logic [NSRC-1:0]              slot_take_o,
    output logic                         walk_start_o,
    output logic                         walk_step_o,
    input  logic                         walk_last_i,
    input  logic [IDX_W-1:0]             walk_set_i,
    input  logic                         walk_dirty_i,
    input  logic [TAG_W-1:0]             walk_tag_i,
    output logic [ADDR_W-1:0]            probe_addr_o,
    input  logic                         probe_dc_hit_i,
    input  logic                         probe_dc_dirty_i,
    input  logic                         probe_ic_hit_i,
    output logic                         wb_req_o,
    output logic [ADDR_W-1:0]            wb_addr_o,
    output logic [BE_W-1:0]              wb_be_o,
    output logic                         dc_inv_all_o,
    output logic                         ic_inv_all_o,
    output logic                         dc_inv_line_o,
    output logic                         ic_inv_line_o,
    output logic [ADDR_W-1:0]            inv_addr_o,
    output logic                         flush_done_pin_o,
    output logic                         flush_done_instr_o
);
    cms_state_e        state_q, state_d;
    cms_kind_e         kind_q, kind_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              src_pin_q, src_instr_q;
    logic [1:0]        pick;
    logic              any_pending;
    logic [ADDR_W-1:0] line_addr;

    // Purpose: choose the lowest-numbered full slot (inquire first)
    always_comb begin
        pick = 2'd0;
        for (int j = NSRC - 1; j >= 0; j--) begin
            if (slot_full_i[j]) pick = 2'(j);
        end
    end

    assign any_pending = |slot_full_i;
    assign line_addr   = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    // Purpose: next state, event capture and slot/walk control
    always_comb begin
        state_d      = state_q;
        kind_d       = kind_q;
        addr_d       = addr_q;
        slot_take_o  = '0;
        walk_start_o = 1'b0;
        walk_step_o  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (flush_pin_i || flush_instr_i) begin
                    state_d      = S_WALK;
                    walk_start_o = 1'b1;
                end else if (any_pending) begin
                    state_d           = S_PROBE;
                    kind_d            = cms_kind_e'(pick);
                    addr_d            = slot_addr_i[pick];
                    slot_take_o[pick] = 1'b1;
                end
            end
            S_WALK: begin
                walk_step_o = 1'b1;
                if (walk_last_i) state_d = S_INVALL;
            end
            S_INVALL: state_d = S_DONE;
            S_DONE:   state_d = S_IDLE;
            S_PROBE: begin
                unique case (kind_q)
                    K_ICF:   state_d = probe_dc_hit_i ? S_INVAL : S_IDLE;
                    K_DCW:   state_d = probe_ic_hit_i ? S_INVAL : S_IDLE;
                    default: state_d = S_IDLE;
                endcase
            end
            S_INVAL: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Purpose: state registers and the latched flush source flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            kind_q      <= K_INQ;
            addr_q      <= '0;
            src_pin_q   <= 1'b0;
            src_instr_q <= 1'b0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            addr_q  <= addr_d;
            if (walk_start_o) begin
                src_pin_q   <= flush_pin_i;
                src_instr_q <= flush_instr_i;
            end
        end
    end

    // Purpose: writeback request from the walk or from a modified probe hit
    always_comb begin
        wb_req_o  = 1'b0;
        wb_addr_o = '0;
        if (state_q == S_WALK) begin
            wb_req_o  = walk_dirty_i;
            wb_addr_o = {walk_tag_i, walk_set_i, {OFF_W{1'b0}}};
        end else if (state_q == S_PROBE && kind_q != K_DCW) begin
            wb_req_o  = probe_dc_hit_i && probe_dc_dirty_i;
            wb_addr_o = line_addr;
        end
        if (!wb_req_o) wb_addr_o = '0;
    end

    assign wb_be_o            = wb_req_o ? {BE_W{1'b1}} : '0;
    assign probe_addr_o       = addr_q;
    assign dc_inv_all_o       = (state_q == S_INVALL);
    assign ic_inv_all_o       = (state_q == S_INVALL);
    assign dc_inv_line_o      = (state_q == S_INVAL) && (kind_q == K_ICF);
    assign ic_inv_line_o      = (state_q == S_INVAL) && (kind_q == K_DCW);
    assign inv_addr_o         = (state_q == S_INVAL) ? line_addr : '0;
    assign flush_done_pin_o   = (state_q == S_DONE) && src_pin_q;
    assign flush_done_instr_o = (state_q == S_DONE) && src_instr_q;

    // R4: the bulk invalidate is followed by at least one acknowledge
    p_ack_after_inv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dc_inv_all_o |=> (flush_done_pin_o || flush_done_instr_o));

    // R4: an acknowledge lasts a single cycle
    p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_done_pin_o || flush_done_instr_o) |=> !(flush_done_pin_o || flush_done_instr_o));

    // R5: a running walk is not restarted by a new flush request
    p_walk_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WALK && !walk_last_i) |=> (state_q == S_WALK && !walk_start_o));

    // R6 and R7: a single-line invalidate comes only right after a probe
    p_inv_after_probe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_inv_line_o || ic_inv_line_o) |-> $past(state_q) == S_PROBE);

    // R10: a writeback always has full byte enables and a line-aligned address
    p_wb_shape_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req_o |-> (wb_be_o == {BE_W{1'b1}} && wb_addr_o[OFF_W-1:0] == '0));

    // R3: no writeback is issued in the cycle of the bulk invalidate
    p_no_wb_at_invall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dc_inv_all_o |-> !wb_req_o);
endmodule

// File: rtl/cache_maint_seq.sv
// Module: top of the cache flush and snoop coherence sequencer.
// Holds one event slot per source and instantiates the walk counter and the controller.
// Assumes: ADDR_W leaves room for a tag above the set index and the 5-bit line offset.
module cache_maint_seq
    import cms_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SETS   = 16,
    parameter int WAYS   = 4,
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_pin_i,
    input  logic              flush_instr_i,
    input  logic              icfill_valid_i,
    input  logic [ADDR_W-1:0] icfill_addr_i,
    input  logic              dcwr_valid_i,
    input  logic [ADDR_W-1:0] dcwr_addr_i,
    input  logic              inq_valid_i,
    input  logic [ADDR_W-1:0] inq_addr_i,
    output logic [IDX_W-1:0]  walk_set_o,
    output logic [WAY_W-1:0]  walk_way_o,
    input  logic              walk_dirty_i,
    input  logic [TAG_W-1:0]  walk_tag_i,
    output logic [ADDR_W-1:0] probe_addr_o,
    input  logic              probe_dc_hit_i,
    input  logic              probe_dc_dirty_i,
    input  logic              probe_ic_hit_i,
    output logic              wb_req_o,
    output logic [ADDR_W-1:0] wb_addr_o,
    output logic [7:0]        wb_be_o,
    output logic              dc_inv_all_o,
    output logic              ic_inv_all_o,
    output logic              dc_inv_line_o,
    output logic              ic_inv_line_o,
    output logic [ADDR_W-1:0] inv_addr_o,
    output logic              flush_done_pin_o,
    output logic              flush_done_instr_o
);
    logic [NSRC-1:0]             ev_valid;
    logic [NSRC-1:0][ADDR_W-1:0] ev_addr;
    logic [NSRC-1:0]             slot_full;
    logic [NSRC-1:0][ADDR_W-1:0] slot_addr;
    logic [NSRC-1:0]             slot_take;
    logic                        walk_start, walk_step, walk_last;

    // Purpose: order the sources by slot index, which is also the service priority
    assign ev_valid[K_INQ] = inq_valid_i;
    assign ev_addr[K_INQ]  = inq_addr_i;
    assign ev_valid[K_ICF] = icfill_valid_i;
    assign ev_addr[K_ICF]  = icfill_addr_i;
    assign ev_valid[K_DCW] = dcwr_valid_i;
    assign ev_addr[K_DCW]  = dcwr_addr_i;

    for (genvar g = 0; g < NSRC; g++) begin : g_slot
        cms_event_slot #(.ADDR_W(ADDR_W)) i_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .ev_valid_i (ev_valid[g]),
            .ev_addr_i  (ev_addr[g]),
            .take_i     (slot_take[g]),
            .full_o     (slot_full[g]),
            .addr_o     (slot_addr[g])
        );
    end

    cms_walk_ctr #(.SETS(SETS), .WAYS(WAYS)) i_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (walk_start),
        .step_i  (walk_step),
        .set_o   (walk_set_o),
        .way_o   (walk_way_o),
        .last_o  (walk_last)
    );

    cms_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_ctrl (
        .clk                (clk),
        .rst_n              (rst_n),
        .flush_pin_i        (flush_pin_i),
        .flush_instr_i      (flush_instr_i),
        .slot_full_i        (slot_full),
        .slot_addr_i        (slot_addr),
        .slot_take_o        (slot_take),
        .walk_start_o       (walk_start),
        .walk_step_o        (walk_step),
        .walk_last_i        (walk_last),
        .walk_set_i         (walk_set_o),
        .walk_dirty_i       (walk_dirty_i),
        .walk_tag_i         (walk_tag_i),
        .probe_addr_o       (probe_addr_o),
        .probe_dc_hit_i     (probe_dc_hit_i),
        .probe_dc_dirty_i   (probe_dc_dirty_i),
        .probe_ic_hit_i     (probe_ic_hit_i),
        .wb_req_o           (wb_req_o),
        .wb_addr_o          (wb_addr_o),
        .wb_be_o            (wb_be_o),
        .dc_inv_all_o       (dc_inv_all_o),
        .ic_inv_all_o       (ic_inv_all_o),
        .dc_inv_line_o      (dc_inv_line_o),
        .ic_inv_line_o      (ic_inv_line_o),
        .inv_addr_o         (inv_addr_o),
        .flush_done_pin_o   (flush_done_pin_o),
        .flush_done_instr_o (flush_done_instr_o)
    );
endmodule

// File: tb/test_cache_maint_seq.sv
// Bench: behavioural cycle model of the sequencer compared on every clock,
// plus directed pulse counts per scenario.
module test_cache_maint_seq;
    localparam int SETS  = 16;
    localparam int WAYS  = 4;
    localparam int IDX_W = 4;
    localparam int TAG_W = 32 - IDX_W - 5;
    localparam int NLINE = SETS * WAYS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush_pin = 1'b0, flush_instr = 1'b0;
    logic icf_v = 1'b0, dcw_v = 1'b0, inq_v = 1'b0;
    logic [31:0] icf_a = '0, dcw_a = '0, inq_a = '0;
    logic [IDX_W-1:0] walk_set;
    logic [1:0] walk_way;
    logic walk_dirty;
    logic [TAG_W-1:0] walk_tag;
    logic [31:0] probe_addr;
    logic p_dhit, p_ddirty, p_ihit;
    logic wb_req, dc_inv_all, ic_inv_all, dc_inv_line, ic_inv_line, ack_pin, ack_instr;
    logic [31:0] wb_addr, inv_addr;
    logic [7:0] wb_be;

    // Bench-side cache image
    bit d_val [SETS][WAYS];
    bit d_dty [SETS][WAYS];
    logic [TAG_W-1:0] d_tag [SETS][WAYS];
    bit i_val [SETS];
    logic [TAG_W-1:0] i_tag [SETS];

    int checks = 0, errors = 0;
    bit done = 1'b0;
    int n_wb = 0, n_ap = 0, n_ai = 0, n_dl = 0, n_il = 0, n_all = 0;

    always #5 clk = ~clk;

    cache_maint_seq i_cache_maint_seq (
        .clk(clk), .rst_n(rst_n),
        .flush_pin_i(flush_pin), .flush_instr_i(flush_instr),
        .icfill_valid_i(icf_v), .icfill_addr_i(icf_a),
        .dcwr_valid_i(dcw_v), .dcwr_addr_i(dcw_a),
        .inq_valid_i(inq_v), .inq_addr_i(inq_a),
        .walk_set_o(walk_set), .walk_way_o(walk_way),
        .walk_dirty_i(walk_dirty), .walk_tag_i(walk_tag),
        .probe_addr_o(probe_addr),
        .probe_dc_hit_i(p_dhit), .probe_dc_dirty_i(p_ddirty), .probe_ic_hit_i(p_ihit),
        .wb_req_o(wb_req), .wb_addr_o(wb_addr), .wb_be_o(wb_be),
        .dc_inv_all_o(dc_inv_all), .ic_inv_all_o(ic_inv_all),
        .dc_inv_line_o(dc_inv_line), .ic_inv_line_o(ic_inv_line), .inv_addr_o(inv_addr),
        .flush_done_pin_o(ack_pin), .flush_done_instr_o(ack_instr)
    );

    function automatic bit dc_hit(logic [31:0] a);
        for (int w = 0; w < WAYS; w++)
            if (d_val[a[5 +: IDX_W]][w] && d_tag[a[5 +: IDX_W]][w] == a[31:5+IDX_W]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit dc_dirty(logic [31:0] a);
        for (int w = 0; w < WAYS; w++)
            if (d_val[a[5 +: IDX_W]][w] && d_tag[a[5 +: IDX_W]][w] == a[31:5+IDX_W]) return d_dty[a[5 +: IDX_W]][w];
        return 1'b0;
    endfunction

    function automatic bit ic_hit(logic [31:0] a);
        return i_val[a[5 +: IDX_W]] && i_tag[a[5 +: IDX_W]] == a[31:5+IDX_W];
    endfunction

    // Cache image answers the lookup ports in the same cycle
    always_comb begin
        walk_dirty = d_val[walk_set][walk_way] && d_dty[walk_set][walk_way];
        walk_tag   = d_tag[walk_set][walk_way];
        p_dhit     = dc_hit(probe_addr);
        p_ddirty   = dc_dirty(probe_addr);
        p_ihit     = ic_hit(probe_addr);
    end

    // Reference model state: 0 idle, 1 walk, 2 bulk invalidate, 3 acknowledge, 4 probe, 5 line invalidate
    int m_st = 0, m_k = 0, m_kind = 0;
    bit m_pin = 0, m_ins = 0;
    logic [31:0] m_addr = '0;
    bit pend [3];
    logic [31:0] paddr [3];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_k = 0; m_kind = 0; m_pin = 0; m_ins = 0; m_addr = '0;
            for (int j = 0; j < 3; j++) begin pend[j] = 0; paddr[j] = '0; end
        end else begin
            case (m_st)
                0: begin
                    if (flush_pin || flush_instr) begin
                        m_st = 1; m_k = 0; m_pin = flush_pin; m_ins = flush_instr;
                    end else begin
                        for (int j = 2; j >= 0; j--) if (pend[j]) m_kind = j;
                        if (pend[0] || pend[1] || pend[2]) begin
                            pend[m_kind] = 0; m_addr = paddr[m_kind]; m_st = 4;
                        end
                    end
                end
                1: if (m_k == NLINE - 1) m_st = 2; else m_k++;
                2: m_st = 3;
                3: m_st = 0;
                4: begin
                    if (m_kind == 1) m_st = dc_hit(m_addr) ? 5 : 0;
                    else if (m_kind == 2) m_st = ic_hit(m_addr) ? 5 : 0;
                    else m_st = 0;
                end
                default: m_st = 0;
            endcase
            if (inq_v) begin pend[0] = 1; paddr[0] = inq_a; end
            if (icf_v) begin pend[1] = 1; paddr[1] = icf_a; end
            if (dcw_v) begin pend[2] = 1; paddr[2] = dcw_a; end
        end
    end

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(posedge clk) begin
        #3;
        if (!done) begin
            bit e_wb, e_all, e_dl, e_il, e_ap, e_ai;
            logic [31:0] e_wa, e_ia, line;
            int s, w;
            e_wb = 0; e_all = 0; e_dl = 0; e_il = 0; e_ap = 0; e_ai = 0; e_wa = '0; e_ia = '0;
            line = {m_addr[31:5], 5'b0};
            if (rst_n) begin
                case (m_st)
                    1: begin
                        s = m_k / WAYS; w = m_k % WAYS;
                        if (d_val[s][w] && d_dty[s][w]) begin
                            e_wb = 1; e_wa = {d_tag[s][w], IDX_W'(s), 5'b0};
                        end
                    end
                    2: e_all = 1;
                    3: begin e_ap = m_pin; e_ai = m_ins; end
                    4: if (m_kind != 2 && dc_hit(m_addr) && dc_dirty(m_addr)) begin e_wb = 1; e_wa = line; end
                    5: begin e_dl = (m_kind == 1); e_il = (m_kind == 2); e_ia = line; end
                    default: ;
                endcase
            end
            chk(wb_req == e_wb, "R2/R6/R8", "wb_req", 32'(wb_req), 32'(e_wb));
            if (e_wb) chk(wb_addr == e_wa, "R2", "wb_addr", wb_addr, e_wa);
            chk(wb_be == (e_wb ? 8'hFF : 8'h00), "R10", "wb_be", 32'(wb_be), e_wb ? 32'hFF : 32'h0);
            chk(dc_inv_all == e_all && ic_inv_all == e_all, "R3", "inv_all", {dc_inv_all, ic_inv_all}, {e_all, e_all});
            chk(dc_inv_line == e_dl, "R6", "dc_inv_line", 32'(dc_inv_line), 32'(e_dl));
            chk(ic_inv_line == e_il, "R7", "ic_inv_line", 32'(ic_inv_line), 32'(e_il));
            if (e_dl || e_il) chk(inv_addr == e_ia, "R7", "inv_addr", inv_addr, e_ia);
            chk(ack_pin == e_ap && ack_instr == e_ai, "R4", "acks", {ack_pin, ack_instr}, {e_ap, e_ai});
            n_wb += int'(wb_req); n_ap += int'(ack_pin); n_ai += int'(ack_instr);
            n_dl += int'(dc_inv_line); n_il += int'(ic_inv_line); n_all += int'(dc_inv_all);
        end
    end

    task automatic clr_counts();
        n_wb = 0; n_ap = 0; n_ai = 0; n_dl = 0; n_il = 0; n_all = 0;
    endtask

    task automatic fill(int seed);
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                d_val[s][w] = ((s + w + seed) % 7) != 0;
                d_dty[s][w] = ((s * 3 + w + seed) % 4) == 0;
                d_tag[s][w] = TAG_W'(s * 16 + w * 3 + seed + 100);
            end
            i_val[s] = ((s + seed) % 2) == 0;
            i_tag[s] = TAG_W'(s * 16 + seed + 100);
        end
    endtask

    function automatic int dirty_lines();
        int n = 0;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                if (d_val[s][w] && d_dty[s][w]) n++;
        return n;
    endfunction

    function automatic logic [31:0] mk_addr(int tag, int set, int off);
        return {TAG_W'(tag), IDX_W'(set), 5'(off)};
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_flush(bit p, bit i);
        @(negedge clk); flush_pin = p; flush_instr = i;
        @(negedge clk); flush_pin = 0; flush_instr = 0;
    endtask

    task automatic pulse_ev(bit vi, logic [31:0] ai, bit vf, logic [31:0] af, bit vd, logic [31:0] ad);
        @(negedge clk); inq_v = vi; inq_a = ai; icf_v = vf; icf_a = af; dcw_v = vd; dcw_a = ad;
        @(negedge clk); inq_v = 0; icf_v = 0; dcw_v = 0;
    endtask

    initial begin
        int exp_wb;
        fill(0);
        step(3);
        rst_n = 1'b1;
        step(2);
        // R1: idle after reset
        chk(!wb_req && !dc_inv_all && !ic_inv_all && !dc_inv_line && !ic_inv_line && !ack_pin && !ack_instr,
            "R1", "outputs after reset", 32'(wb_req), 32'h0);

        // R2 R3 R4: pin flush
        clr_counts(); exp_wb = dirty_lines();
        pulse_flush(1, 0); step(NLINE + 6);
        chk(n_wb == exp_wb, "R2", "pin flush writeback count", n_wb, exp_wb);
        chk(n_all == 1, "R3", "bulk invalidate count", n_all, 1);
        chk(n_ap == 1 && n_ai == 0, "R4", "pin flush acks", {n_ap[15:0], n_ai[15:0]}, 32'h10000);

        // R4: instruction flush, different image
        fill(3); clr_counts(); exp_wb = dirty_lines();
        pulse_flush(0, 1); step(NLINE + 6);
        chk(n_wb == exp_wb, "R2", "instr flush writeback count", n_wb, exp_wb);
        chk(n_ap == 0 && n_ai == 1, "R4", "instr flush acks", {n_ap[15:0], n_ai[15:0]}, 32'h1);

        // R4: both triggers in the same cycle
        clr_counts();
        pulse_flush(1, 1); step(NLINE + 6);
        chk(n_ap == 1 && n_ai == 1, "R4", "dual flush acks", {n_ap[15:0], n_ai[15:0]}, 32'h10001);

        // R5: flushes during a walk are ignored
        clr_counts();
        pulse_flush(1, 0); step(10);
        pulse_flush(1, 1); step(20);
        pulse_flush(0, 1); step(NLINE + 6);
        chk(n_ap == 1 && n_ai == 0, "R5", "ignored flush acks", {n_ap[15:0], n_ai[15:0]}, 32'h10000);
        chk(n_all == 1, "R5", "single bulk invalidate", n_all, 1);

        // R6: fill snoop hitting a modified data line, a clean one, a miss
        d_val[3][1] = 1; d_dty[3][1] = 1; d_tag[3][1] = TAG_W'(777);
        d_val[5][2] = 1; d_dty[5][2] = 0; d_tag[5][2] = TAG_W'(888);
        clr_counts();
        pulse_ev(0, '0, 1, mk_addr(777, 3, 12), 0, '0); step(5);
        chk(n_wb == 1 && n_dl == 1, "R6", "modified snoop wb+inv", {n_wb[15:0], n_dl[15:0]}, 32'h10001);
        clr_counts();
        pulse_ev(0, '0, 1, mk_addr(888, 5, 3), 0, '0); step(5);
        chk(n_wb == 0 && n_dl == 1, "R6", "clean snoop inv only", {n_wb[15:0], n_dl[15:0]}, 32'h1);
        clr_counts();
        pulse_ev(0, '0, 1, mk_addr(999, 5, 0), 0, '0); step(5);
        chk(n_wb == 0 && n_dl == 0, "R6", "snoop miss", {n_wb[15:0], n_dl[15:0]}, 32'h0);

        // R7: data-write snoop of the instruction cache
        i_val[6] = 1; i_tag[6] = TAG_W'(555);
        clr_counts();
        pulse_ev(0, '0, 0, '0, 1, mk_addr(555, 6, 31)); step(5);
        chk(n_il == 1 && n_wb == 0, "R7", "icache snoop hit", {n_il[15:0], n_wb[15:0]}, 32'h10000);
        clr_counts();
        pulse_ev(0, '0, 0, '0, 1, mk_addr(556, 6, 0)); step(5);
        chk(n_il == 0, "R7", "icache snoop miss", n_il, 0);

        // R8: inquire on modified and clean lines
        clr_counts();
        pulse_ev(1, mk_addr(777, 3, 8), 0, '0, 0, '0); step(5);
        chk(n_wb == 1 && n_dl == 0 && n_il == 0, "R8", "inquire modified", {n_wb[15:0], n_dl[15:0]}, 32'h10000);
        clr_counts();
        pulse_ev(1, mk_addr(888, 5, 0), 0, '0, 0, '0); step(5);
        chk(n_wb == 0, "R8", "inquire clean", n_wb, 0);

        // R9: events held during a walk, served afterwards in priority order
        clr_counts();
        pulse_flush(0, 1); step(4);
        pulse_ev(0, '0, 0, '0, 1, mk_addr(555, 6, 0)); step(3);
        pulse_ev(0, '0, 1, mk_addr(777, 3, 0), 0, '0); step(3);
        pulse_ev(1, mk_addr(777, 3, 0), 0, '0, 0, '0); step(NLINE + 20);
        chk(n_ai == 1 && n_dl == 1 && n_il == 1, "R9", "held events served", {n_dl[15:0], n_il[15:0]}, 32'h10001);

        // R11: flush and a fill snoop in the same cycle: flush goes first
        clr_counts();
        @(negedge clk); flush_pin = 1; icf_v = 1; icf_a = mk_addr(888, 5, 0);
        @(negedge clk); flush_pin = 0; icf_v = 0;
        step(NLINE + 10);
        chk(n_ap == 1 && n_dl == 1, "R11", "flush first then snoop", {n_ap[15:0], n_dl[15:0]}, 32'h10001);

        // R2: fully clean image gives no writebacks
        for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) d_dty[s][w] = 0;
        clr_counts();
        pulse_flush(1, 0); step(NLINE + 6);
        chk(n_wb == 0 && n_ap == 1, "R2", "clean flush", {n_wb[15:0], n_ap[15:0]}, 32'h1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule